// File: doc/BRIEF.md
# UART Modem Status and Interrupt Controller

This block sits beside a UART frame engine. It watches the four active-low modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input passes through a synchroniser. The block keeps sticky change flags for the inputs and reports their present levels in asserted (inverted) form. It drives the active-low DTR and RTS outputs, and it has a diagnostic loopback mode that feeds its own control outputs back into the modem inputs.

The block also merges four interrupt sources into one interrupt line and a prioritised identification code. The sources are line status, receive-full, transmit-empty and modem status. The frame engine supplies the receive and error levels and a transmit-empty strobe. Software reaches the block through a small register port with four word addresses. Reads of that port take effect combinationally, and their side effects apply at the clock edge that ends the read cycle.

Top module: `uart_event_irq`

## Requirements
- R1: A change in either direction on ctsN, dsrN or dcdN, once synchronised, sets a sticky flag in the modem status word (address 3). The flag bits are: bit 0 for CTS, bit 1 for DSR and bit 3 for DCD. The flag is readable on the third rising edge after the pin changes.
- R2: Status bit 2 (the trailing-ring flag) is set only when riN goes from low to high. A high-to-low change on riN leaves the flag clear.
- R3: Status bits [7:4] show the complements of the synchronised dcdN, riN, dsrN and ctsN, in that order from bit 7 down. They update on the second rising edge after the pin changes.
- R4: A read of address 3 clears all four flags at the end of the read cycle. A flag event in that same cycle is kept.
- R5: The enable word at address 0 reads back as written. Its bits are: bit 0 receive-full, bit 1 transmit-empty, bit 2 line status, bit 3 modem status. With bit 3 set, any set flag raises the interrupt.
- R6: The line-status source is active when bit 2 of the enable word is set and any of rxReady, overrunErr, parityErr or framingErr is high. The receive-full source is active when bit 0 is set and rxReady is high.
- R7: A one-cycle pulse on txEmptyStb latches a transmit-empty request. Only a read of address 1 while the code reported there is 01 clears that request.
- R8: Address 1 reads {5'b0, code[1:0], idle}. The codes, from highest priority to lowest, are: 11 line status, 10 receive-full, 01 transmit-empty, 00 modem status. The idle bit is 1 and the code is 00 when nothing is pending. irqOut is high exactly when a source is pending. The code follows the sources in the same cycle.
- R9: The control word at address 2 reads back as written. Bit 0 asserts DTR and bit 1 asserts RTS, giving dtrN = ~bit0 and rtsN = ~bit1. Bit 2 selects loopback and appears on loopOut.
- R10: In loopback, dtrN and rtsN are held high and the external modem pins are ignored. The internal inputs are driven as follows: CTS and RI from the RTS control, DSR and DCD from the DTR control, all with active-low polarity.
- R11: After reset, every register is zero, no flag is set, address 1 reads 0x01, irqOut is low, and dtrN and rtsN are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; read side effects apply at the closing edge |
| addr | input | 2 | Register word address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational on addr |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsrN | input | 1 | Data-set-ready pin, active low, asynchronous |
| riN | input | 1 | Ring indicator pin, active low, asynchronous |
| dcdN | input | 1 | Carrier detect pin, active low, asynchronous |
| rxReady | input | 1 | Frame engine holds a received character |
| overrunErr | input | 1 | Frame engine overrun condition |
| parityErr | input | 1 | Frame engine parity error condition |
| framingErr | input | 1 | Frame engine framing error condition |
| txEmptyStb | input | 1 | One-cycle pulse when the transmit buffer empties |
| irqOut | output | 1 | Combined interrupt request |
| dtrN | output | 1 | DTR output, active low |
| rtsN | output | 1 | RTS output, active low |
| loopOut | output | 1 | Loopback mode indication to the frame engine |

## Verification
A pin change shows in the level bits two edges after the change and in the flags three edges after it. A control-word write reaches the internal loopback lines one edge later, so every pin or loopback stimulus is followed by four idle cycles before the status word is read. Interrupt codes and pin outputs are combinational on registered state, so the bench probes them in the cycle after the stimulus, at the falling clock edge. Each clearing read is followed by a second read that confirms the clear took effect at the edge ending the first.

// File: rtl/uart_msi_pkg.sv
package uart_msi_pkg;

  typedef enum logic [1:0] {
    REG_IEN = 2'd0,
    REG_IID = 2'd1,
    REG_MCR = 2'd2,
    REG_MSR = 2'd3
  } regAddr_e;

  typedef enum logic [1:0] {
    SRC_MODEM = 2'b00,
    SRC_TXE   = 2'b01,
    SRC_RXF   = 2'b10,
    SRC_LINE  = 2'b11
  } srcCode_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic clrModem;
    logic clrTxEmpty;
    logic loopback;
    logic dtrOn;
    logic rtsOn;
  } dpCtl_t;

endpackage

// File: rtl/uart_msi_datapath.sv
module uart_msi_datapath
  import uart_msi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       txEmptyStb,
  output logic [3:0] msFlags,
  output logic [3:0] levels,
  output logic       txPend
);
  localparam int NUM_LINES = 4;
  localparam int RING_IDX  = 2;

  logic [NUM_LINES-1:0] rawN;
  logic [NUM_LINES-1:0] syncN;
  logic [NUM_LINES-1:0] prevN;
  logic [NUM_LINES-1:0] edgeHit;
  logic loopDtrN, loopRtsN;

  assign loopDtrN = ~ctl.dtrOn;
  assign loopRtsN = ~ctl.rtsOn;

  // index: 3 dcd, 2 ri, 1 dsr, 0 cts
  always_comb begin
    if (ctl.loopback) rawN = {loopDtrN, loopRtsN, loopDtrN, loopRtsN};
    else              rawN = {dcdN, riN, dsrN, ctsN};
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[i]};
    end
    assign syncN[i] = chain[SYNC_STAGES-1];

    if (i == RING_IDX) begin : gTrail
      assign edgeHit[i] = syncN[i] & ~prevN[i];
    end else begin : gDelta
      assign edgeHit[i] = syncN[i] ^ prevN[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevN   <= '1;
      msFlags <= '0;
      txPend  <= 1'b0;
    end else begin
      prevN   <= syncN;
      msFlags <= (ctl.clrModem ? '0 : msFlags) | edgeHit;
      if (txEmptyStb)          txPend <= 1'b1;
      else if (ctl.clrTxEmpty) txPend <= 1'b0;
    end
  end

  assign levels = ~syncN;
endmodule

// File: rtl/uart_msi_ctrl.sv
module uart_msi_ctrl
  import uart_msi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxReady,
  input  logic              overrunErr,
  input  logic              parityErr,
  input  logic              framingErr,
  input  logic [3:0]        msFlags,
  input  logic [3:0]        levels,
  input  logic              txPend,
  output dpCtl_t            ctl,
  output logic [DATA_W-1:0] ienBits,
  output logic [DATA_W-1:0] idCode,
  output logic              irqOut,
  output logic              dtrN,
  output logic              rtsN,
  output logic              loopOut
);
  localparam int PAD_W = DATA_W - 3;

  logic [DATA_W-1:0] ienReg, mcrReg;
  logic lineSrc, rxSrc, txSrc, msSrc, pending;
  srcCode_e code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienReg <= '0;
      mcrReg <= '0;
    end else if (wrEn) begin
      if (addr == REG_IEN) ienReg <= wrData;
      if (addr == REG_MCR) mcrReg <= wrData;
    end
  end

  assign lineSrc = ienReg[2] & (rxReady | overrunErr | parityErr | framingErr);
  assign rxSrc   = ienReg[0] & rxReady;
  assign txSrc   = ienReg[1] & txPend;
  assign msSrc   = ienReg[3] & (|msFlags);
  assign pending = lineSrc | rxSrc | txSrc | msSrc;

  always_comb begin
    if (lineSrc)    code = SRC_LINE;
    else if (rxSrc) code = SRC_RXF;
    else if (txSrc) code = SRC_TXE;
    else            code = SRC_MODEM;
  end

  assign idCode  = {{PAD_W{1'b0}}, code, ~pending};
  assign irqOut  = pending;
  assign ienBits = ienReg;

  always_comb begin
    ctl.clrModem   = rdEn && (addr == REG_MSR);
    ctl.clrTxEmpty = rdEn && (addr == REG_IID) && txSrc && (code == SRC_TXE);
    ctl.loopback   = mcrReg[2];
    ctl.dtrOn      = mcrReg[0];
    ctl.rtsOn      = mcrReg[1];
  end

  assign dtrN    = mcrReg[2] | ~mcrReg[0];
  assign rtsN    = mcrReg[2] | ~mcrReg[1];
  assign loopOut = mcrReg[2];

  always_comb begin
    case (addr)
      REG_IEN: rdData = ienReg;
      REG_IID: rdData = idCode;
      REG_MCR: rdData = mcrReg;
      default: rdData = DATA_W'({levels, msFlags});
    endcase
  end
endmodule

// File: rtl/uart_event_irq.sv
module uart_event_irq
  import uart_msi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              riN,
  input  logic              dcdN,
  input  logic              rxReady,
  input  logic              overrunErr,
  input  logic              parityErr,
  input  logic              framingErr,
  input  logic              txEmptyStb,
  output logic              irqOut,
  output logic              dtrN,
  output logic              rtsN,
  output logic              loopOut
);
  dpCtl_t            ctl;
  logic [3:0]        msFlags;
  logic [3:0]        levels;
  logic              txPend;
  logic [DATA_W-1:0] idCode;
  logic [DATA_W-1:0] ienBits;

  uart_msi_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .txEmptyStb(txEmptyStb),
    .msFlags(msFlags), .levels(levels), .txPend(txPend)
  );

  uart_msi_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .rxReady(rxReady), .overrunErr(overrunErr), .parityErr(parityErr),
    .framingErr(framingErr),
    .msFlags(msFlags), .levels(levels), .txPend(txPend),
    .ctl(ctl), .ienBits(ienBits), .idCode(idCode), .irqOut(irqOut),
    .dtrN(dtrN), .rtsN(rtsN), .loopOut(loopOut)
  );
endmodule

// File: rtl/uart_msi_checker.sv
module uart_msi_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [1:0]        addr,
  input logic              rxReady,
  input logic              overrunErr,
  input logic              parityErr,
  input logic              framingErr,
  input logic              txEmptyStb,
  input logic [3:0]        msFlags,
  input logic              txPend,
  input logic [DATA_W-1:0] idCode,
  input logic [DATA_W-1:0] ienBits,
  input logic              irqOut,
  input logic              dtrN,
  input logic              rtsN,
  input logic              loopOut
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(msFlags) & ~msFlags)) |-> $past(rdEn && addr == 2'd3)); // R4

  AST_TXE_SET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPend) |-> $past(txEmptyStb)); // R7

  AST_TXE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txPend) |-> $past(rdEn && addr == 2'd1)); // R7

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    loopOut |-> (dtrN && rtsN)); // R10

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    idCode[0] |-> (idCode[2:1] == 2'b00 && !irqOut)); // R8

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ienBits[2] && (rxReady || overrunErr || parityErr || framingErr))
      |-> (idCode[2:0] == 3'b110)); // R6

  AST_MODEM_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (ienBits[3] && (|msFlags)) |-> irqOut); // R5
endmodule

bind uart_event_irq uart_msi_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr),
  .rxReady(rxReady), .overrunErr(overrunErr), .parityErr(parityErr),
  .framingErr(framingErr), .txEmptyStb(txEmptyStb),
  .msFlags(msFlags), .txPend(txPend), .idCode(idCode), .ienBits(ienBits),
  .irqOut(irqOut), .dtrN(dtrN), .rtsN(rtsN), .loopOut(loopOut)
);

// File: tb/tb_uart_event_irq.sv
`timescale 1ns/1ps
module tb_uart_event_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, probe = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic rxReady = 1'b0, overrunErr = 1'b0, parityErr = 1'b0, framingErr = 1'b0;
  logic txEmptyStb = 1'b0;
  logic irqOut, dtrN, rtsN, loopOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    bit       isPin;
    bit [7:0] exp;
    string    tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  uart_event_irq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .rxReady(rxReady), .overrunErr(overrunErr), .parityErr(parityErr),
    .framingErr(framingErr), .txEmptyStb(txEmptyStb),
    .irqOut(irqOut), .dtrN(dtrN), .rtsN(rtsN), .loopOut(loopOut)
  );

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rdEn || probe) begin
      if (sb.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard empty");
      end else begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = it.isPin ? {4'b0, irqOut, loopOut, dtrN, rtsN} : rdData;
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.isPin = 1'b0; it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sb.push_back(it);
    addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  // expected {irq, loop, dtrN, rtsN}
  task automatic pinChk(input logic [7:0] e, input string tag);
    item_t it;
    it.isPin = 1'b1; it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sb.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic pulseTx();
    @(posedge clk); #1;
    txEmptyStb = 1'b1;
    @(posedge clk); #1;
    txEmptyStb = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R11 reset state
    rdChk(2'd3, 8'h00, "R11 status after reset");
    rdChk(2'd1, 8'h01, "R11 id after reset");
    rdChk(2'd0, 8'h00, "R11 enables after reset");
    pinChk(8'h03, "R11 pins after reset");

    // R1 R3 cts change
    ctsN = 1'b0; idle(4);
    rdChk(2'd3, 8'h11, "R1 cts delta and R3 level");
    rdChk(2'd3, 8'h10, "R4 flags cleared by read");

    // R2 ring falling then rising
    riN = 1'b0; idle(4);
    rdChk(2'd3, 8'h50, "R2 no flag on falling ring");
    riN = 1'b1; idle(4);
    rdChk(2'd3, 8'h14, "R2 trailing flag on rising ring");
    rdChk(2'd3, 8'h10, "R4 ring flag cleared");

    // R1 dsr and dcd
    dsrN = 1'b0; dcdN = 1'b0; idle(4);
    rdChk(2'd3, 8'hBA, "R1 dsr dcd deltas R3 levels");
    rdChk(2'd3, 8'hB0, "R4 cleared keeps levels");

    // R5 modem interrupt
    wr(2'd0, 8'h08);
    rdChk(2'd0, 8'h08, "R5 enable readback");
    ctsN = 1'b1; idle(4);
    rdChk(2'd1, 8'h00, "R8 modem code");
    pinChk(8'h0B, "R5 irq from modem flag");
    rdChk(2'd3, 8'hA1, "R1 cts release delta");
    rdChk(2'd1, 8'h01, "R8 idle after modem clear");
    pinChk(8'h03, "R8 irq low when idle");

    wr(2'd0, 8'h00);
    dsrN = 1'b1; dcdN = 1'b1; idle(4);
    rdChk(2'd3, 8'h0A, "R1 dsr dcd release");

    // R7 transmit empty
    wr(2'd0, 8'h0A);
    pulseTx(); idle(1);
    rdChk(2'd1, 8'h02, "R7 tx empty code");
    rdChk(2'd1, 8'h01, "R7 tx cleared by id read");

    // R8 priority tx over modem
    pulseTx();
    ctsN = 1'b0; idle(4);
    rdChk(2'd1, 8'h02, "R8 tx over modem");
    rdChk(2'd1, 8'h00, "R8 modem after tx cleared");
    rdChk(2'd3, 8'h11, "R1 cts delta again");
    rdChk(2'd1, 8'h01, "R8 idle");

    // R6 R7 receive over tx; id read on rx code keeps tx
    wr(2'd0, 8'h0B);
    pulseTx();
    rxReady = 1'b1; idle(1);
    rdChk(2'd1, 8'h04, "R6 receive full code");
    rxReady = 1'b0; idle(1);
    rdChk(2'd1, 8'h02, "R7 tx kept across rx read");
    rdChk(2'd1, 8'h01, "R7 tx cleared");

    // R6 line status
    wr(2'd0, 8'h0F);
    rxReady = 1'b1; idle(1);
    rdChk(2'd1, 8'h06, "R6 line over rx");
    rxReady = 1'b0; parityErr = 1'b1; idle(1);
    rdChk(2'd1, 8'h06, "R6 parity line status");
    parityErr = 1'b0;
    wr(2'd0, 8'h04);
    overrunErr = 1'b1; idle(1);
    rdChk(2'd1, 8'h06, "R6 overrun line status");
    overrunErr = 1'b0; framingErr = 1'b1; idle(1);
    rdChk(2'd1, 8'h06, "R6 framing line status");
    framingErr = 1'b0; idle(1);
    rdChk(2'd1, 8'h01, "R6 line idle");

    // R9 control outputs
    ctsN = 1'b1; idle(4);
    rdChk(2'd3, 8'h01, "R1 cts release before loopback");
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    pinChk(8'h01, "R9 dtr asserted");
    wr(2'd2, 8'h03);
    pinChk(8'h00, "R9 dtr rts asserted");

    // R10 loopback
    wr(2'd2, 8'h07);
    pinChk(8'h07, "R10 pins idle in loopback");
    idle(4);
    rdChk(2'd3, 8'hFB, "R10 looped lines asserted");
    rdChk(2'd3, 8'hF0, "R4 looped flags cleared");
    wr(2'd2, 8'h05);
    idle(4);
    rdChk(2'd3, 8'hA5, "R10 rts drop loops to cts and ring");
    ctsN = 1'b0; riN = 1'b0; idle(4);
    rdChk(2'd3, 8'hA0, "R10 external pins ignored");
    rdChk(2'd2, 8'h05, "R9 control readback");
    wr(2'd2, 8'h00);
    pinChk(8'h03, "R9 pins released");
    idle(4);
    rdChk(2'd3, 8'h5B, "R10 external pins return after loopback");

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule